// File: doc/BRIEF.md
# Management-Memory Address Strobe Steering

This block sits in a processor's bus interface unit. When a bus cycle begins, it chooses which of two active-low address strobes to pulse. One is the ordinary strobe for main memory. The other is a separate strobe for the protected management memory that the system-management handler uses. The choice depends on three things: whether the core is in management mode, whether the access is an instruction fetch or a data access, and whether the address falls inside a management region whose base and size software can program.

The block also holds that region configuration. Alongside it is a control bit that lets the handler reach main memory lying underneath the region, but only for data accesses. Code fetches that hit the region always stay in management memory. A lock bit freezes the configuration until the next reset, so that ordinary software cannot move or disable the region once the firmware has set it up.

Top module: `smm_strobe_steer`

## Requirements
- R1: After reset both strobes are high, the region base is 0, the size code is 0 (a 4 KB region), and the overlap bit and the lock bit are both clear.
- R2: For each clock in which `cycle_start` is high, exactly one of `ads_n`/`smads_n` is low during the following clock only. Both strobes are high in every other clock.
- R3: When `in_smm` is low, every cycle pulses `ads_n`.
- R4: When `in_smm` is high and the overlap bit is clear, any access (fetch or data) whose address lies inside the region pulses `smads_n`.
- R5: When `in_smm` is high, any access outside the region pulses `ads_n`.
- R6: Size code n (written to select 1, low 5 bits) gives a region of 2^(12+n) bytes. Codes above 20 act as 20. An address hits when its bits above the size boundary equal those of the base, so base bits below the boundary are ignored.
- R7: With the overlap bit set (select 2, bit 0), data accesses (`is_fetch` low) in management mode that hit the region pulse `ads_n`.
- R8: Instruction fetches in management mode that hit the region pulse `smads_n`, whatever the overlap bit holds.
- R9: Writing 1 to the lock bit (select 2, bit 1) makes all later writes to base (select 0), size (select 1) and control (select 2) have no effect until reset.
- R10: A configuration write taken in the same clock as `cycle_start` does not affect that cycle's strobe choice; it applies from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | A bus cycle begins in this clock |
| addr | input | 32 | Byte address of the cycle |
| is_fetch | input | 1 | 1 = instruction fetch, 0 = data read/write |
| in_smm | input | 1 | Core is in management mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 size code, 2 control, 3 unused |
| cfg_wdata | input | 32 | Configuration write data |
| ads_n | output | 1 | Main-memory address strobe, active low |
| smads_n | output | 1 | Management-memory address strobe, active low |

## Verification
The embedded assertions check the following on every cycle:
- the one-strobe, one-clock pulse shape;
- that cycles outside management mode and region misses pick the normal strobe;
- that fetch hits pick the management strobe;
- that a set lock stays set and freezes the stored configuration.

Some behaviours are only shown by the directed scenarios: the size-code decoding and clamping, the ignoring of low base bits, the overlap steering of data accesses, the reset contents of the configuration, and the ordering of a write against a cycle in the same clock. The scenarios check these against a model of the region kept in the bench.

// File: rtl/smm_steer_pkg.sv
package smm_steer_pkg;

   // register select codes on the configuration port
   typedef enum logic [1:0] {
      CFG_BASE = 2'd0,
      CFG_SIZE = 2'd1,
      CFG_CTRL = 2'd2,
      CFG_NONE = 2'd3
   } cfg_sel_e;

   // control register bit positions
   localparam int CTRL_OVL_BIT  = 0;
   localparam int CTRL_LOCK_BIT = 1;

   // strobe choice for one bus cycle
   typedef enum logic {
      STB_MAIN = 1'b0,
      STB_MGMT = 1'b1
   } strobe_e;

endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
   import smm_steer_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int SZ_W     = 5,
   parameter int MAX_CODE = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [1:0]        sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] base_o,
   output logic [SZ_W-1:0]   size_code_o,
   output logic              ovl_o,
   output logic              lock_o
);

   initial begin
      if (SZ_W < 1 || MAX_CODE >= (1 << SZ_W))
         $error("smm_cfg_regs: SZ_W too narrow for MAX_CODE");
      if (ADDR_W < SZ_W || ADDR_W < 2)
         $error("smm_cfg_regs: ADDR_W too small");
   end

   logic              wr_ok;
   logic [SZ_W-1:0]   code_in;
   logic [SZ_W-1:0]   code_clamped;

   assign wr_ok   = we && !lock_o;
   assign code_in = wdata[SZ_W-1:0];

   always_comb begin
      if (code_in > SZ_W'(MAX_CODE))
         code_clamped = SZ_W'(MAX_CODE);
      else
         code_clamped = code_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o      <= '0;
         size_code_o <= '0;
         ovl_o       <= 1'b0;
         lock_o      <= 1'b0;
      end else if (wr_ok) begin
         unique case (cfg_sel_e'(sel))
            CFG_BASE: base_o      <= wdata;
            CFG_SIZE: size_code_o <= code_clamped;
            CFG_CTRL: begin
               ovl_o  <= wdata[CTRL_OVL_BIT];
               lock_o <= wdata[CTRL_LOCK_BIT];
            end
            default: ;
         endcase
      end
   end

   // once set, the lock only falls with reset
   assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_o) |-> lock_o)
      else $error("lock bit cleared without reset");

   // a locked configuration never changes
   assert_locked_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_o) |-> ($stable(base_o) && $stable(size_code_o) && $stable(ovl_o)))
      else $error("locked configuration changed");

   // the stored size code never exceeds the largest region
   assert_code_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      size_code_o <= SZ_W'(MAX_CODE))
      else $error("size code out of range");

endmodule

// File: rtl/smm_region_match.sv
module smm_region_match #(
   parameter int ADDR_W    = 32,
   parameter int MIN_LOG2  = 12,
   parameter int NUM_SIZES = 21,
   parameter int SZ_W      = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SZ_W-1:0]   size_code,
   output logic              hit
);

   initial begin
      if (MIN_LOG2 + NUM_SIZES - 1 > ADDR_W)
         $error("smm_region_match: largest region exceeds address space");
      if (ADDR_W > 62)
         $error("smm_region_match: ADDR_W above 62 not supported");
   end

   // one upper-bits mask per size code
   logic [ADDR_W-1:0] mask_tbl [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_mask
      localparam logic [63:0] LOWBITS = (64'd1 << (MIN_LOG2 + g)) - 64'd1;
      assign mask_tbl[g] = ~LOWBITS[ADDR_W-1:0];
   end

   logic [ADDR_W-1:0] mask;

   always_comb begin
      mask = mask_tbl[NUM_SIZES-1];
      for (int i = 0; i < NUM_SIZES; i++) begin
         if (size_code == SZ_W'(i))
            mask = mask_tbl[i];
      end
   end

   assign hit = ((addr ^ base) & mask) == '0;

endmodule

// File: rtl/smm_strobe_gen.sv
module smm_strobe_gen
   import smm_steer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cycle_start,
   input  logic in_smm,
   input  logic is_fetch,
   input  logic hit,
   input  logic ovl,
   output logic ads_n,
   output logic smads_n
);

   strobe_e choice;

   always_comb begin
      choice = STB_MAIN;
      if (in_smm && hit && (is_fetch || !ovl))
         choice = STB_MGMT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ads_n   <= 1'b1;
         smads_n <= 1'b1;
      end else begin
         ads_n   <= !(cycle_start && choice == STB_MAIN);
         smads_n <= !(cycle_start && choice == STB_MGMT);
      end
   end

   // exactly one strobe after a cycle start
   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cycle_start) |-> $countones({~ads_n, ~smads_n}) == 1)
      else $error("not exactly one strobe");

   // idle clocks leave both strobes high
   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cycle_start) |-> (ads_n && smads_n))
      else $error("strobe without cycle start");

   // outside management mode only the main strobe
   assert_normal_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cycle_start && !in_smm) |-> !ads_n)
      else $error("management strobe outside management mode");

   // region miss goes to main memory
   assert_miss_main_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cycle_start && !hit) |-> !ads_n)
      else $error("miss did not use main strobe");

   // fetch hits always go to management memory
   assert_fetch_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cycle_start && in_smm && is_fetch && hit) |-> !smads_n)
      else $error("fetch hit left management memory");

endmodule

// File: rtl/smm_strobe_steer.sv
module smm_strobe_steer
   import smm_steer_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int MIN_LOG2 = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cycle_start,
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_fetch,
   input  logic              in_smm,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic              ads_n,
   output logic              smads_n
);

   localparam int NUM_SIZES = ADDR_W - MIN_LOG2 + 1;
   localparam int MAX_CODE  = NUM_SIZES - 1;
   localparam int SZ_W      = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1;

   initial begin
      if (MIN_LOG2 < 1 || MIN_LOG2 >= ADDR_W)
         $error("smm_strobe_steer: MIN_LOG2 must lie in 1..ADDR_W-1");
   end

   logic [ADDR_W-1:0] base;
   logic [SZ_W-1:0]   size_code;
   logic              ovl;
   logic              lock;
   logic              hit;

   smm_cfg_regs #(
      .ADDR_W  (ADDR_W),
      .SZ_W    (SZ_W),
      .MAX_CODE(MAX_CODE)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (cfg_we),
      .sel        (cfg_sel),
      .wdata      (cfg_wdata),
      .base_o     (base),
      .size_code_o(size_code),
      .ovl_o      (ovl),
      .lock_o     (lock)
   );

   smm_region_match #(
      .ADDR_W   (ADDR_W),
      .MIN_LOG2 (MIN_LOG2),
      .NUM_SIZES(NUM_SIZES),
      .SZ_W     (SZ_W)
   ) u_match (
      .addr     (addr),
      .base     (base),
      .size_code(size_code),
      .hit      (hit)
   );

   smm_strobe_gen u_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .cycle_start(cycle_start),
      .in_smm     (in_smm),
      .is_fetch   (is_fetch),
      .hit        (hit),
      .ovl        (ovl),
      .ads_n      (ads_n),
      .smads_n    (smads_n)
   );

   // lock is consumed only by the register block; keep it observable here
   assert_never_both_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(!ads_n && !smads_n))
      else $error("both strobes low (lock=%0b)", lock);

endmodule

// File: tb/tb_smm_strobe_steer.sv
`timescale 1ns/1ps
module tb_smm_strobe_steer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cycle_start = 1'b0;
   logic [31:0] addr = '0;
   logic        is_fetch = 1'b0;
   logic        in_smm = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        ads_n;
   logic        smads_n;

   int n_checks = 0;
   int n_fail   = 0;

   // bench model of the configuration
   logic [31:0] m_base;
   int          m_code;
   logic        m_ovl;
   logic        m_lock;

   always #2.5 clk = ~clk;

   smm_strobe_steer dut (
      .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .addr(addr),
      .is_fetch(is_fetch), .in_smm(in_smm), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .ads_n(ads_n), .smads_n(smads_n)
   );

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {ads_n,smads_n} actual=%b expected=%b", req, act, exp);
      end
   endtask

   // expected strobe pair for a cycle, from the requirements
   function automatic logic [1:0] expect_pair(input logic [31:0] a, input logic f, input logic s);
      int  lg;
      logic hitm;
      lg   = 12 + ((m_code > 20) ? 20 : m_code);
      hitm = ((64'(a) ^ 64'(m_base)) >> lg) == 64'd0;
      if (s && hitm && (f || !m_ovl)) return 2'b10;
      return 2'b01;
   endfunction

   task automatic model_write(input logic [1:0] s, input logic [31:0] d);
      if (!m_lock) begin
         case (s)
            2'd0: m_base = d;
            2'd1: m_code = (d[4:0] > 5'd20) ? 20 : int'(d[4:0]);
            2'd2: begin m_ovl = d[0]; m_lock = d[1]; end
            default: ;
         endcase
      end
   endtask

   task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_write(s, d);
   endtask

   task automatic bus_cycle(input string req, input logic [31:0] a, input logic f, input logic s);
      logic [1:0] exp;
      exp = expect_pair(a, f, s);
      @(negedge clk);
      cycle_start = 1'b1; addr = a; is_fetch = f; in_smm = s;
      @(negedge clk);
      cycle_start = 1'b0;
      chk(req, {ads_n, smads_n}, exp);
      @(negedge clk);
      chk("R2 idle after pulse", {ads_n, smads_n}, 2'b11);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 strobes high after reset", {ads_n, smads_n}, 2'b11);
      bus_cycle("R1 default region hit", 32'h0000_0100, 1'b0, 1'b1);
      bus_cycle("R1 default 4KB edge miss", 32'h0000_1000, 1'b0, 1'b1);
   endtask

   task automatic t_normal_mode;
      cfg_write(2'd0, 32'h0003_0000);
      cfg_write(2'd1, 32'd4);
      bus_cycle("R3 fetch in region, normal mode", 32'h0003_0010, 1'b1, 1'b0);
      bus_cycle("R3 data in region, normal mode", 32'h0003_8000, 1'b0, 1'b0);
      // back-to-back starts: one pulse per start
      @(negedge clk);
      cycle_start = 1'b1; addr = 32'h0003_0000; is_fetch = 1'b0; in_smm = 1'b1;
      @(negedge clk);
      addr = 32'h0005_0000;
      chk("R2 back-to-back first", {ads_n, smads_n}, 2'b10);
      @(negedge clk);
      cycle_start = 1'b0;
      chk("R2 back-to-back second", {ads_n, smads_n}, 2'b01);
      @(negedge clk);
      chk("R2 idle after burst", {ads_n, smads_n}, 2'b11);
   endtask

   task automatic t_smm_hits;
      bus_cycle("R4 data hit", 32'h0003_FFFC, 1'b0, 1'b1);
      bus_cycle("R4 fetch hit", 32'h0003_0000, 1'b1, 1'b1);
      bus_cycle("R5 data miss above", 32'h0004_0000, 1'b0, 1'b1);
      bus_cycle("R5 fetch miss below", 32'h0002_FFFF, 1'b1, 1'b1);
   endtask

   task automatic t_sizes;
      cfg_write(2'd1, 32'd0);
      bus_cycle("R6 4KB last byte", 32'h0003_0FFF, 1'b0, 1'b1);
      bus_cycle("R6 4KB first miss", 32'h0003_1000, 1'b0, 1'b1);
      cfg_write(2'd1, 32'd20);
      bus_cycle("R6 4GB covers all", 32'hFFFF_FFF0, 1'b0, 1'b1);
      cfg_write(2'd1, 32'd27);
      bus_cycle("R6 code clamped to 4GB", 32'h8000_0000, 1'b1, 1'b1);
      cfg_write(2'd1, 32'd4);
      cfg_write(2'd0, 32'h0003_1234);
      bus_cycle("R6 base low bits ignored", 32'h0003_0004, 1'b0, 1'b1);
   endtask

   task automatic t_overlap;
      cfg_write(2'd2, 32'h1);
      bus_cycle("R7 data hit to main", 32'h0003_2000, 1'b0, 1'b1);
      bus_cycle("R8 fetch hit ignores overlap", 32'h0003_2000, 1'b1, 1'b1);
      bus_cycle("R3 overlap, normal mode", 32'h0003_2000, 1'b1, 1'b0);
      cfg_write(2'd2, 32'h0);
      bus_cycle("R4 overlap cleared", 32'h0003_2000, 1'b0, 1'b1);
   endtask

   task automatic t_same_cycle;
      logic [1:0] exp;
      exp = expect_pair(32'h0003_0040, 1'b0, 1'b1);
      @(negedge clk);
      cycle_start = 1'b1; addr = 32'h0003_0040; is_fetch = 1'b0; in_smm = 1'b1;
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h1;
      @(negedge clk);
      cycle_start = 1'b0; cfg_we = 1'b0;
      model_write(2'd2, 32'h1);
      chk("R10 write same cycle uses old config", {ads_n, smads_n}, exp);
      bus_cycle("R10 write applies next cycle", 32'h0003_0040, 1'b0, 1'b1);
      cfg_write(2'd2, 32'h0);
   endtask

   task automatic t_lock;
      cfg_write(2'd2, 32'h2);
      cfg_write(2'd2, 32'h1);
      bus_cycle("R9 overlap write ignored", 32'h0003_0080, 1'b0, 1'b1);
      cfg_write(2'd0, 32'h0010_0000);
      bus_cycle("R9 base write ignored (old)", 32'h0003_0080, 1'b1, 1'b1);
      bus_cycle("R9 base write ignored (new)", 32'h0010_0000, 1'b1, 1'b1);
      cfg_write(2'd1, 32'd20);
      bus_cycle("R9 size write ignored", 32'h0050_0000, 1'b1, 1'b1);
      cfg_write(2'd2, 32'h0);
      cfg_write(2'd2, 32'h1);
      bus_cycle("R9 lock not clearable", 32'h0003_0080, 1'b0, 1'b1);
   endtask

   task automatic t_reset_clears_lock;
      @(negedge clk);
      rst_n = 1'b0;
      m_base = '0; m_code = 0; m_ovl = 1'b0; m_lock = 1'b0;
      @(negedge clk);
      chk("R1 strobes high in reset", {ads_n, smads_n}, 2'b11);
      rst_n = 1'b1;
      cfg_write(2'd2, 32'h1);
      bus_cycle("R1 lock cleared by reset", 32'h0000_0010, 1'b0, 1'b1);
   endtask

   initial begin
      m_base = '0; m_code = 0; m_ovl = 1'b0; m_lock = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_normal_mode();
      t_smm_hits();
      t_sizes();
      t_overlap();
      t_same_cycle();
      t_lock();
      t_reset_clears_lock();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule